// File: doc/BRIEF.md
# Algorithm-Driven Clock and Idle Mode Controller

This block manages the clock of a signal-processing subsystem that runs one of several speech coding algorithms. A supervisory controller selects the active algorithm and strobes a load. The block then commands a matching multiplier for a PLL that is fed from a fixed 8.192 MHz reference. It waits for the PLL to report lock before any domain clock is allowed to run.

Between bursts of processing, the supervisor can request one of two idle levels:

- **Level 1** gates only the core domain.
- **Level 2** gates both the core domain and the peripheral domain, which holds the timer and the serial port.

An interrupt brings the subsystem back to full operation. When waking from level 2, the peripheral domain is released one cycle before the core. A packed status output reports the current mode and the active multiplier.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, the state is RELOCK (code 1), the multiplier is 10 (81.92 MHz), both clock enables are 0 and `relock_wait` is 1.
- R2: In RELOCK, both enables stay 0 and `relock_wait` stays 1. The block moves to RUN (code 0) at the first clock edge where `pll_lock` is 1.
- R3: In RUN, an `alg_load` pulse sets the multiplier from `alg_sel` at the next edge and enters RELOCK. The mapping is 0→10 (unmanaged), 1→4 (600 bps, 32.768 MHz), 2→5 (1200 bps, 40.960 MHz) and 3→3 (2400 bps, 24.576 MHz).
- R4: An `alg_load` pulse outside RUN has no effect on the multiplier or the state.
- R5: In RUN, both `core_clk_en` and `peri_clk_en` are 1 and `relock_wait` is 0.
- R6: In RUN, `idle_req` with `idle_lvl`=0 enters IDLE1 (code 2), where the core enable is 0 and the peripheral enable is 1. In IDLE1, `irq` returns the block to RUN at the next edge.
- R7: In RUN, `idle_req` with `idle_lvl`=1 enters IDLE2 (code 3), where both enables are 0. In IDLE2, `irq` moves the block to WAKE (code 4) for exactly one cycle, with the peripheral enable at 1 and the core enable at 0. The block then enters RUN.
- R8: An `idle_req` that arrives in the same cycle as `irq` is ignored, and the block stays in RUN.
- R9: When `alg_load` and `idle_req` arrive in the same RUN cycle, the load wins and the block enters RELOCK.
- R10: `status` is {state code[2:0], multiplier[3:0]}, and its lower four bits always equal `mult_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| alg_load | input | 1 | Strobe that loads `alg_sel` |
| alg_sel | input | 2 | Algorithm selector |
| idle_req | input | 1 | Request to enter an idle level |
| idle_lvl | input | 1 | 0 selects idle level 1, 1 selects idle level 2 |
| irq | input | 1 | Wake interrupt; also blocks idle entry |
| pll_lock | input | 1 | PLL lock indication |
| mult_code | output | 4 | Multiplier sent to the PLL |
| relock_wait | output | 1 | High while waiting for PLL lock |
| core_clk_en | output | 1 | Core domain clock enable |
| peri_clk_en | output | 1 | Timer and serial port domain clock enable |
| status | output | 7 | State code and active multiplier |

## Verification
Two collisions are provoked on purpose.

- **Idle request with interrupt.** An idle request is driven in the same RUN cycle as an interrupt. Both enables are expected to stay high, with the state code still at RUN.
- **Idle request with algorithm load.** An idle request is driven in the same cycle as an algorithm load. This is judged by the state entering RELOCK with the new multiplier, rather than entering an idle level.

A scoreboard compares every output field after each edge. Because of this, a wrong winner in either collision shows up as a mismatch in the state code or in the enables.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    localparam int MULT_W = 4;
    localparam int ALG_W  = 2;
    localparam int ST_W   = 3;

    localparam logic [MULT_W-1:0] MULT_DEFAULT = 4'd10;
    localparam logic [MULT_W-1:0] MULT_600     = 4'd4;
    localparam logic [MULT_W-1:0] MULT_1200    = 4'd5;
    localparam logic [MULT_W-1:0] MULT_2400    = 4'd3;

    typedef enum logic [ST_W-1:0] {
        ST_RUN    = 3'd0,
        ST_RELOCK = 3'd1,
        ST_IDLE1  = 3'd2,
        ST_IDLE2  = 3'd3,
        ST_WAKE   = 3'd4
    } pm_state_t;

    typedef struct packed {
        logic core_en;
        logic peri_en;
        logic relock;
    } pm_gate_t;

    function automatic logic [MULT_W-1:0] alg_to_mult(input logic [ALG_W-1:0] alg);
        case (alg)
            2'd1:    return MULT_600;
            2'd2:    return MULT_1200;
            2'd3:    return MULT_2400;
            default: return MULT_DEFAULT;
        endcase
    endfunction
endpackage

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      alg_load,
    input  logic      idle_req,
    input  logic      idle_lvl,
    input  logic      irq,
    input  logic      pll_lock,
    output pm_state_t state,
    output logic      load_go
);
    pm_state_t state_nx;

    assign load_go = (state == ST_RUN) && alg_load;

    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN: begin
                if (alg_load)
                    state_nx = ST_RELOCK;
                else if (idle_req && !irq)
                    state_nx = idle_lvl ? ST_IDLE2 : ST_IDLE1;
            end
            ST_RELOCK: if (pll_lock) state_nx = ST_RUN;
            ST_IDLE1:  if (irq) state_nx = ST_RUN;
            ST_IDLE2:  if (irq) state_nx = ST_WAKE;
            ST_WAKE:   state_nx = ST_RUN;
            default:   state_nx = ST_RELOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RELOCK;
        else     state <= state_nx;
    end

    // R8: pending interrupt blocks idle entry
    assert_idle_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && idle_req && irq && !alg_load) |=> state == ST_RUN);

    // R7: wake from level 2 passes through WAKE for one cycle
    assert_wake_path_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE2 && irq) |=> (state == ST_WAKE) ##1 (state == ST_RUN));

    // R2: relock is left only with lock
    assert_relock_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RELOCK && !pll_lock) |=> state == ST_RELOCK);
endmodule

// File: rtl/pm_mult_sel.sv
module pm_mult_sel
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_go,
    input  logic [ALG_W-1:0]  alg_sel,
    output logic [MULT_W-1:0] mult
);
    always_ff @(posedge clk) begin
        if (rst)          mult <= MULT_DEFAULT;
        else if (load_go) mult <= alg_to_mult(alg_sel);
    end

    // R4: multiplier moves only on an accepted load
    assert_mult_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load_go |=> $stable(mult));
endmodule

// File: rtl/pm_gate_dec.sv
module pm_gate_dec
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pm_state_t state,
    output pm_gate_t  gate
);
    always_comb begin
        gate = '{core_en: 1'b0, peri_en: 1'b0, relock: 1'b0};
        case (state)
            ST_RUN:    gate = '{core_en: 1'b1, peri_en: 1'b1, relock: 1'b0};
            ST_IDLE1:  gate.peri_en = 1'b1;
            ST_WAKE:   gate.peri_en = 1'b1;
            ST_RELOCK: gate.relock  = 1'b1;
            default:   gate = '{core_en: 1'b0, peri_en: 1'b0, relock: 1'b0};
        endcase
    end

    // R2: no domain clock while waiting for lock
    assert_gated_relock_R2: assert property (@(posedge clk) disable iff (rst)
        gate.relock |-> !gate.core_en && !gate.peri_en);

    // R6: the core never runs without the peripheral domain
    assert_core_needs_peri_R6: assert property (@(posedge clk) disable iff (rst)
        gate.core_en |-> gate.peri_en);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        alg_load,
    input  logic [1:0]  alg_sel,
    input  logic        idle_req,
    input  logic        idle_lvl,
    input  logic        irq,
    input  logic        pll_lock,
    output logic [3:0]  mult_code,
    output logic        relock_wait,
    output logic        core_clk_en,
    output logic        peri_clk_en,
    output logic [6:0]  status
);
    pm_state_t state;
    logic      load_go;
    pm_gate_t  gate;
    logic [MULT_W-1:0] mult;

    pm_mode_fsm i_fsm (
        .clk(clk), .rst(rst), .alg_load(alg_load), .idle_req(idle_req),
        .idle_lvl(idle_lvl), .irq(irq), .pll_lock(pll_lock),
        .state(state), .load_go(load_go)
    );

    pm_mult_sel i_mult (
        .clk(clk), .rst(rst), .load_go(load_go), .alg_sel(alg_sel), .mult(mult)
    );

    pm_gate_dec i_gate (
        .clk(clk), .rst(rst), .state(state), .gate(gate)
    );

    assign mult_code   = mult;
    assign relock_wait = gate.relock;
    assign core_clk_en = gate.core_en;
    assign peri_clk_en = gate.peri_en;
    assign status      = {state, mult};

    // R3: an accepted load always starts a relock
    assert_load_relock_R3: assert property (@(posedge clk) disable iff (rst)
        load_go |=> relock_wait);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alg_load = 1'b0, idle_req = 1'b0, idle_lvl = 1'b0, irq = 1'b0, pll_lock = 1'b0;
    logic [1:0] alg_sel = 2'd0;
    logic [3:0] mult_code;
    logic relock_wait, core_clk_en, peri_clk_en;
    logic [6:0] status;

    int checks = 0;
    int errors = 0;
    logic [10:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .alg_load(alg_load), .alg_sel(alg_sel),
        .idle_req(idle_req), .idle_lvl(idle_lvl), .irq(irq), .pll_lock(pll_lock),
        .mult_code(mult_code), .relock_wait(relock_wait), .core_clk_en(core_clk_en),
        .peri_clk_en(peri_clk_en), .status(status)
    );

    // expected item: {state[2:0], mult[3:0], core, peri, relock, 1'b0}
    task automatic step(input logic r, input logic ld, input logic [1:0] a,
                        input logic ir, input logic lv, input logic it, input logic lk,
                        input logic [2:0] st, input logic [3:0] m,
                        input logic c, input logic p, input logic rw, input string tag);
        @(negedge clk);
        rst = r; alg_load = ld; alg_sel = a; idle_req = ir; idle_lvl = lv;
        irq = it; pll_lock = lk;
        exp_q.push_back({st, m, c, p, rw, 1'b0});
        tag_q.push_back(tag);
    endtask

    // monitor: compares one item per clock edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [10:0] e;
            logic [10:0] act;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = {status[6:4], mult_code, core_clk_en, peri_clk_en, relock_wait,
                   (status[3:0] != mult_code)};
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s: actual st=%0d m=%0d c=%b p=%b rw=%b smis=%b expected st=%0d m=%0d c=%b p=%b rw=%b smis=0",
                         t, act[10:8], act[7:4], act[3], act[2], act[1], act[0],
                         e[10:8], e[7:4], e[3], e[2], e[1]);
            end
        end
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        //    rst ld alg ir lv it lk   st  m    c  p  rw
        step(1, 0, 0, 0, 0, 0, 0, 3'd1, 4'd10, 0, 0, 1, "R1 reset");
        step(0, 0, 0, 0, 0, 0, 0, 3'd1, 4'd10, 0, 0, 1, "R2 wait lock");
        step(0, 0, 0, 0, 0, 0, 1, 3'd0, 4'd10, 1, 1, 0, "R5 run after lock");
        step(0, 1, 1, 0, 0, 0, 0, 3'd1, 4'd4,  0, 0, 1, "R3 load 600");
        step(0, 0, 0, 0, 0, 0, 0, 3'd1, 4'd4,  0, 0, 1, "R2 relock hold");
        step(0, 0, 0, 0, 0, 0, 1, 3'd0, 4'd4,  1, 1, 0, "R2 relock exit");
        step(0, 1, 2, 0, 0, 0, 0, 3'd1, 4'd5,  0, 0, 1, "R3 load 1200");
        step(0, 0, 0, 0, 0, 0, 1, 3'd0, 4'd5,  1, 1, 0, "R10 status run");
        step(0, 1, 3, 0, 0, 0, 0, 3'd1, 4'd3,  0, 0, 1, "R3 load 2400");
        step(0, 0, 0, 0, 0, 0, 1, 3'd0, 4'd3,  1, 1, 0, "R5 run");
        step(0, 0, 0, 1, 0, 0, 0, 3'd2, 4'd3,  0, 1, 0, "R6 enter idle1");
        step(0, 1, 1, 0, 0, 0, 0, 3'd2, 4'd3,  0, 1, 0, "R4 load in idle1");
        step(0, 0, 0, 0, 0, 1, 0, 3'd0, 4'd3,  1, 1, 0, "R6 wake idle1");
        step(0, 0, 0, 1, 1, 1, 0, 3'd0, 4'd3,  1, 1, 0, "R8 idle with irq");
        step(0, 0, 0, 1, 1, 0, 0, 3'd3, 4'd3,  0, 0, 0, "R7 enter idle2");
        step(0, 1, 2, 0, 0, 0, 0, 3'd3, 4'd3,  0, 0, 0, "R4 load in idle2");
        step(0, 0, 0, 0, 0, 1, 0, 3'd4, 4'd3,  0, 1, 0, "R7 wake peri first");
        step(0, 0, 0, 0, 0, 0, 0, 3'd0, 4'd3,  1, 1, 0, "R7 core follows");
        step(0, 1, 0, 1, 0, 0, 0, 3'd1, 4'd10, 0, 0, 1, "R9 load beats idle");
        step(0, 0, 0, 1, 0, 0, 0, 3'd1, 4'd10, 0, 0, 1, "R2 idle in relock");
        step(0, 0, 0, 0, 0, 0, 1, 3'd0, 4'd10, 1, 1, 0, "R10 status default");
        step(0, 0, 0, 0, 0, 0, 0, 3'd0, 4'd10, 1, 1, 0, "R5 run hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule